// File: doc/BRIEF.md
# Interlace-capable raster timing generator

The block produces the pixel and line counters, horizontal and vertical sync, horizontal and vertical blanking, and a field flag for a raster display. All geometry is held in programmable registers, loaded through a simple write port. These are the horizontal total, the active width, the horizontal sync window, the vertical total, the first active line, and a vertical sync window. The vertical sync window is given as a start point and an end point, each a line plus a pixel position. The two pixel positions are held in separate pairs for odd and even fields.

Register writes act on the very next clock, with no synchronization. The run control comes from another clock domain and is the only input that passes through a two-flop synchronizer. While the generator is stopped, the counters are parked at the last pixel of the last line, the sync outputs are low and both blanking outputs are high. Because the counters are parked there, the first position after a start is line 0, pixel 0. The active region begins at a programmable line, so every start opens with a full vertical blank period that contains the vertical sync.

In interlaced mode, the vertical total describes one field rather than a frame. The odd field is one line longer than the even field.

Top module: `raster_timing_gen`

## Requirements
- R1: `hcount_o` steps by one each cycle while running and returns to 0 after reaching the horizontal total, so a line lasts horizontal total + 1 cycles. `vcount_o` steps by one at each horizontal wrap.
- R2: With the interlace bit (bit 0 of register 12) clear, `vcount_o` runs from 0 to the vertical total. A frame therefore lasts (vertical total + 1) lines, and `field_o` stays 0.
- R3: With the interlace bit set, `field_o` toggles at every vertical wrap. A field with `field_o`=1 (odd) lasts vertical total + 2 lines, and a field with `field_o`=0 (even) lasts vertical total + 1 lines.
- R4: While running, `hblank_o` is high when `hcount_o` is at or above the active width, and `vblank_o` is high when `vcount_o` is below the first active line.
- R5: While running, `hsync_o` is high when the hsync start is at or below `hcount_o` and `hcount_o` is below the hsync end.
- R6: While running, `vsync_o` is high from (start line, start pixel) inclusive up to (end line, end pixel) exclusive. The pixel pair comes from registers 8/9 when `field_o`=1 and from registers 10/11 when `field_o`=0, so progressive mode uses the even pair.
- R7: The run input reaches the counters after two clock edges. While stopped, or while in reset, `hsync_o` and `vsync_o` are 0 and `hblank_o` and `vblank_o` are 1. While stopped, the counters are loaded with the horizontal and vertical totals and `field_o` is 0. Reset clears the counters.
- R8: On the clock edge after the synchronized run goes high, the counters move to line 0, pixel 0. That position lies inside vertical blank and inside vertical sync when the sync window opens there.
- R9: A write to register address a (0 horizontal total, 1 active width, 2 hsync start, 3 hsync end, 4 vertical total, 5 first active line, 6 vsync start line, 7 vsync end line, 8/9 odd start/end pixel, 10/11 even start/end pixel, 12 control) takes effect in the cycle after the write edge. No synchronization is applied.
- R10: The horizontal counter wraps when it is at or above the total. Lowering the total below the current count therefore ends the line on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Start/stop request, asynchronous to clk_i |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 4 | Register address |
| cfg_wdata_i | input | CW | Register write data |
| hcount_o | output | CW | Pixel counter |
| vcount_o | output | CW | Line counter |
| field_o | output | 1 | 1 for odd field, 0 for even field |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| hblank_o | output | 1 | Horizontal blanking |
| vblank_o | output | 1 | Vertical blanking |

## Verification
The bench measures the odd and even field lengths in interlaced mode. A design that added the extra line to the wrong field, or to both fields, would show 200 and 220 swapped or equal.

It checks the vsync start pixel at the top of each field. Selecting the pixel pair by the wrong field would put the edge at pixel 0 on an odd field.

It shrinks the horizontal total while the counter is already past the new value. A wrap-on-equality design would then run on to counter overflow.

Start and stop are timed edge by edge. A missing or extra synchronizer stage, or a restart that does not begin at line 0 inside vertical sync, shows up one cycle early, one cycle late, or without sync.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;
  localparam int unsigned ADDR_W     = 4;
  localparam int unsigned NUM_TIMING = 12;

  typedef enum logic [ADDR_W-1:0] {
    REG_H_TOTAL    = 4'd0,
    REG_H_DISP     = 4'd1,
    REG_HS_ON      = 4'd2,
    REG_HS_OFF     = 4'd3,
    REG_V_TOTAL    = 4'd4,
    REG_V_ACT      = 4'd5,
    REG_VS_LN_ON   = 4'd6,
    REG_VS_LN_OFF  = 4'd7,
    REG_VS_X_ON_O  = 4'd8,
    REG_VS_X_OFF_O = 4'd9,
    REG_VS_X_ON_E  = 4'd10,
    REG_VS_X_OFF_E = 4'd11,
    REG_CTRL       = 4'd12
  } reg_idx_e;

  localparam int unsigned CTRL_ILACE_BIT = 0;
endpackage

// File: rtl/vtg_cfg_regs.sv
`timescale 1ns/1ps
module vtg_cfg_regs
  import vtg_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [CW-1:0]                    wdata_i,
  output logic [NUM_TIMING-1:0][CW-1:0]    timing_o,
  output logic                             ilace_o
);

  for (genvar i = 0; i < NUM_TIMING; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  timing_o[i] <= '0;
      else if (we_i && addr_i == ADDR_W'(i))        timing_o[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              ilace_o <= 1'b0;
    else if (we_i && addr_i == REG_CTRL)      ilace_o <= wdata_i[CTRL_ILACE_BIT];
  end

  // R9: write visible the cycle after the write edge
  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i < ADDR_W'(NUM_TIMING)) |=> timing_o[$past(addr_i)] == $past(wdata_i));

  a_r9_ctrl_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_CTRL) |=> ilace_o == $past(wdata_i[CTRL_ILACE_BIT]));

endmodule

// File: rtl/vtg_run_sync.sv
`timescale 1ns/1ps
module vtg_run_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic run_o
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], run_i};
  end

  assign run_o = chain_q[STAGES-1];

  if (STAGES == 2) begin : g_chk
    // R7: a start seen at the output was requested two edges earlier
    a_r7_sync_lag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(run_o) |-> $past(run_i, 2));
  end

endmodule

// File: rtl/vtg_raster_cnt.sv
`timescale 1ns/1ps
module vtg_raster_cnt #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          ilace_i,
  input  logic [CW-1:0] h_total_i,
  input  logic [CW-1:0] v_total_i,
  output logic [CW-1:0] hcnt_o,
  output logic [CW-1:0] vcnt_o,
  output logic          field_o
);

  localparam int unsigned XW = CW + 1;

  logic [CW-1:0] hcnt_q, vcnt_q;
  logic          field_q;
  logic          h_end, v_end;
  logic [XW-1:0] v_last;

  // odd field carries one extra line
  assign v_last = {1'b0, v_total_i} + XW'(field_q);
  assign h_end  = hcnt_q >= h_total_i;
  assign v_end  = {1'b0, vcnt_q} >= v_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      vcnt_q  <= '0;
      field_q <= 1'b0;
    end else if (!run_i) begin
      // park on the final pixel so the first step lands on line 0
      hcnt_q  <= h_total_i;
      vcnt_q  <= v_total_i;
      field_q <= 1'b0;
    end else if (h_end) begin
      hcnt_q <= '0;
      if (v_end) begin
        vcnt_q  <= '0;
        field_q <= ilace_i ? ~field_q : 1'b0;
      end else begin
        vcnt_q <= vcnt_q + 1'b1;
      end
    end else begin
      hcnt_q <= hcnt_q + 1'b1;
    end
  end

  assign hcnt_o  = hcnt_q;
  assign vcnt_o  = vcnt_q;
  assign field_o = field_q;

  a_r1_h_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && ($past(hcnt_q) < $past(h_total_i)))
      |-> hcnt_q == $past(hcnt_q) + 1'b1);

  a_r10_h_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && ($past(hcnt_q) >= $past(h_total_i))) |-> hcnt_q == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (hcnt_q == $past(h_total_i)) && (vcnt_q == $past(v_total_i)) && !field_q);

  a_r3_field_at_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && (field_q != $past(field_q))) |-> (hcnt_q == '0) && (vcnt_q == '0));

  a_r2_prog_field: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ilace_i && !field_q) |=> !field_q);

endmodule

// File: rtl/vtg_decode.sv
`timescale 1ns/1ps
module vtg_decode #(
  parameter int unsigned CW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [CW-1:0] hcnt_i,
  input  logic [CW-1:0] vcnt_i,
  input  logic          field_i,
  input  logic [CW-1:0] h_disp_i,
  input  logic [CW-1:0] hs_on_i,
  input  logic [CW-1:0] hs_off_i,
  input  logic [CW-1:0] v_act_i,
  input  logic [CW-1:0] vs_ln_on_i,
  input  logic [CW-1:0] vs_ln_off_i,
  input  logic [CW-1:0] vs_x_on_odd_i,
  input  logic [CW-1:0] vs_x_off_odd_i,
  input  logic [CW-1:0] vs_x_on_even_i,
  input  logic [CW-1:0] vs_x_off_even_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          hblank_o,
  output logic          vblank_o
);

  logic [CW-1:0] vs_x_on, vs_x_off;
  logic          vs_started, vs_open, hs_win;

  assign vs_x_on  = field_i ? vs_x_on_odd_i  : vs_x_on_even_i;
  assign vs_x_off = field_i ? vs_x_off_odd_i : vs_x_off_even_i;

  assign vs_started = (vcnt_i > vs_ln_on_i) ||
                      ((vcnt_i == vs_ln_on_i) && (hcnt_i >= vs_x_on));
  assign vs_open    = (vcnt_i < vs_ln_off_i) ||
                      ((vcnt_i == vs_ln_off_i) && (hcnt_i < vs_x_off));
  assign hs_win     = (hcnt_i >= hs_on_i) && (hcnt_i < hs_off_i);

  always_comb begin
    hsync_o  = 1'b0;
    vsync_o  = 1'b0;
    hblank_o = 1'b1;
    vblank_o = 1'b1;
    if (run_i) begin
      hsync_o  = hs_win;
      vsync_o  = vs_started && vs_open;
      hblank_o = hcnt_i >= h_disp_i;
      vblank_o = vcnt_i < v_act_i;
    end
  end

  a_r7_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !hsync_o && !vsync_o && hblank_o && vblank_o);

  // R6: sync cannot be active before the start line
  a_r6_vs_before_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcnt_i < vs_ln_on_i) |-> !vsync_o);

endmodule

// File: rtl/raster_timing_gen.sv
`timescale 1ns/1ps
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int unsigned CW          = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CW-1:0]     cfg_wdata_i,
  output logic [CW-1:0]     hcount_o,
  output logic [CW-1:0]     vcount_o,
  output logic              field_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              hblank_o,
  output logic              vblank_o
);

  logic [NUM_TIMING-1:0][CW-1:0] tcfg;
  logic                          ilace;
  logic                          run_s;
  logic [CW-1:0]                 hcnt, vcnt;
  logic                          field;

  vtg_cfg_regs #(.CW(CW)) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .timing_o (tcfg),
    .ilace_o  (ilace)
  );

  vtg_run_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run_i),
    .run_o  (run_s)
  );

  vtg_raster_cnt #(.CW(CW)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_s),
    .ilace_i   (ilace),
    .h_total_i (tcfg[REG_H_TOTAL]),
    .v_total_i (tcfg[REG_V_TOTAL]),
    .hcnt_o    (hcnt),
    .vcnt_o    (vcnt),
    .field_o   (field)
  );

  vtg_decode #(.CW(CW)) i_dec (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .run_i           (run_s),
    .hcnt_i          (hcnt),
    .vcnt_i          (vcnt),
    .field_i         (field),
    .h_disp_i        (tcfg[REG_H_DISP]),
    .hs_on_i         (tcfg[REG_HS_ON]),
    .hs_off_i        (tcfg[REG_HS_OFF]),
    .v_act_i         (tcfg[REG_V_ACT]),
    .vs_ln_on_i      (tcfg[REG_VS_LN_ON]),
    .vs_ln_off_i     (tcfg[REG_VS_LN_OFF]),
    .vs_x_on_odd_i   (tcfg[REG_VS_X_ON_O]),
    .vs_x_off_odd_i  (tcfg[REG_VS_X_OFF_O]),
    .vs_x_on_even_i  (tcfg[REG_VS_X_ON_E]),
    .vs_x_off_even_i (tcfg[REG_VS_X_OFF_E]),
    .hsync_o         (hsync_o),
    .vsync_o         (vsync_o),
    .hblank_o        (hblank_o),
    .vblank_o        (vblank_o)
  );

  assign hcount_o = hcnt;
  assign vcount_o = vcnt;
  assign field_o  = field;

  // R8: first step after start lands on line 0, pixel 0
  a_r8_restart_origin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_s) |=> (hcnt == '0) && (vcnt == '0));

endmodule

// File: tb/test_raster_timing_gen.sv
`timescale 1ns/1ps
module test_raster_timing_gen;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic          we = 1'b0;
  logic [3:0]    addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] hcount, vcount;
  logic          field, hsync, vsync, hblank, vblank;

  raster_timing_gen #(.CW(CW)) i_raster_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .hcount_o(hcount), .vcount_o(vcount), .field_o(field),
    .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank)
  );

  always #2 clk = ~clk;

  int n_run = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model + scoreboard ----------------
  typedef struct { int hc; int vc; int f; int hs; int vs; int hb; int vb; } exp_t;
  exp_t exp_q[$];
  bit   sb_on = 1'b0;

  int m_cfg [13];
  int m_h, m_v, m_f, m_s1, m_s2;

  function automatic exp_t predict();
    exp_t e;
    int xs, xe;
    bit st, op;
    e.hc = m_h; e.vc = m_v; e.f = m_f;
    xs = m_f ? m_cfg[8] : m_cfg[10];
    xe = m_f ? m_cfg[9] : m_cfg[11];
    st = (m_v > m_cfg[6]) || (m_v == m_cfg[6] && m_h >= xs);
    op = (m_v < m_cfg[7]) || (m_v == m_cfg[7] && m_h < xe);
    e.hs = (m_s2 != 0) && m_h >= m_cfg[2] && m_h < m_cfg[3];
    e.vs = (m_s2 != 0) && st && op;
    e.hb = (m_s2 == 0) || m_h >= m_cfg[1];
    e.vb = (m_s2 == 0) || m_v < m_cfg[5];
    return e;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_f = 0; m_s1 = 0; m_s2 = 0;
      for (int i = 0; i < 13; i++) m_cfg[i] = 0;
    end else begin
      if (m_s2 == 0) begin
        m_h = m_cfg[0]; m_v = m_cfg[4]; m_f = 0;
      end else if (m_h >= m_cfg[0]) begin
        m_h = 0;
        if (m_v >= m_cfg[4] + m_f) begin
          m_v = 0;
          m_f = (m_cfg[12] & 1) ? 1 - m_f : 0;
        end else m_v = m_v + 1;
      end else m_h = m_h + 1;
      m_s2 = m_s1;
      m_s1 = run;
      if (we && addr < 4'd12) m_cfg[addr] = int'(wdata);
      if (we && addr == 4'd12) m_cfg[12] = int'(wdata[0]);
      if (sb_on) exp_q.push_back(predict());
    end
  end

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(int'(hcount) == e.hc, "R1", "hcount", int'(hcount), e.hc);
      chk(int'(vcount) == e.vc, "R1", "vcount", int'(vcount), e.vc);
      chk(int'(field) == e.f, "R3", "field", int'(field), e.f);
      chk(int'(hblank) == e.hb && int'(vblank) == e.vb, "R4", "blank h*2+v",
          int'(hblank) * 2 + int'(vblank), e.hb * 2 + e.vb);
      chk(int'(hsync) == e.hs, "R5", "hsync", int'(hsync), e.hs);
      chk(int'(vsync) == e.vs, "R6", "vsync", int'(vsync), e.vs);
    end
  end

  // ---------------- driver ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    we = 1'b1; addr = 4'(a); wdata = CW'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int c;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(hcount == 0 && vcount == 0 && !hsync && !vsync && hblank && vblank && !field,
        "R7", "reset state ok", 0, 1);
    rst_n = 1'b1;

    wr(0, 19); wr(1, 14); wr(2, 15); wr(3, 18);
    wr(4, 9);  wr(5, 3);  wr(6, 0);  wr(7, 1);
    wr(8, 5);  wr(9, 5);  wr(10, 0); wr(11, 0); wr(12, 0);
    @(negedge clk);
    sb_on = 1'b1;
    @(negedge clk);

    // R7/R8: start timing
    run = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(hcount == 19 && vcount == 9, "R7", "parked h*100+v", int'(hcount) * 100 + int'(vcount), 1909);
    @(negedge clk);
    chk(hcount == 0 && vcount == 0, "R8", "origin h*100+v", int'(hcount) * 100 + int'(vcount), 0);
    chk(vblank && vsync, "R8", "vblank&vsync at restart", int'(vblank && vsync), 1);

    // R2: progressive frame length
    c = 0;
    do begin
      @(negedge clk); c++;
      if (field) chk(0, "R2", "field in progressive", 1, 0);
    end while (!(hcount == 0 && vcount == 0));
    chk(c == 200, "R2", "frame cycles", c, 200);

    // R3/R6: interlaced fields
    wr(12, 1);
    while (!field) @(negedge clk);
    chk(!vsync, "R6", "odd vsync at pixel 0", int'(vsync), 0);
    c = 0;
    do begin
      @(negedge clk); c++;
      if (c == 4) chk(!vsync, "R6", "odd vsync at pixel 4", int'(vsync), 0);
      if (c == 5) chk(vsync, "R6", "odd vsync at pixel 5", int'(vsync), 1);
    end while (field);
    chk(c == 220, "R3", "odd field cycles", c, 220);
    chk(vsync, "R6", "even vsync at pixel 0", int'(vsync), 1);
    c = 0;
    do begin @(negedge clk); c++; end while (!field);
    chk(c == 200, "R3", "even field cycles", c, 200);

    // R10/R9: shrink h_total past current count
    while (hcount != 15) @(negedge clk);
    we = 1'b1; addr = 4'd0; wdata = CW'(10);
    @(negedge clk);
    we = 1'b0;
    chk(hcount == 16, "R9", "count before new total", int'(hcount), 16);
    @(negedge clk);
    chk(hcount == 0, "R10", "wrap past shrunk total", int'(hcount), 0);
    c = 0;
    do begin @(negedge clk); c++; end while (hcount != 0);
    chk(c == 11, "R9", "shrunk line cycles", c, 11);
    wr(0, 19);

    // R5: hsync window edges
    while (hcount != 14) @(negedge clk);
    chk(!hsync, "R5", "hsync at 14", int'(hsync), 0);
    @(negedge clk);
    chk(hsync, "R5", "hsync at 15", int'(hsync), 1);
    repeat (3) @(negedge clk);
    chk(!hsync, "R5", "hsync at 18", int'(hsync), 0);

    // R4: blanking edges
    while (!(vcount == 3 && hcount == 13)) @(negedge clk);
    chk(!vblank && !hblank, "R4", "active at (13,3)", int'(vblank || hblank), 0);
    @(negedge clk);
    chk(hblank, "R4", "hblank at 14", int'(hblank), 1);

    // R7: stop
    run = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(!hsync && !vsync && hblank && vblank, "R7", "quiet after stop", 0, 0);
    @(negedge clk);
    chk(hcount == 19 && vcount == 9 && !field, "R7", "parked after stop",
        int'(hcount) * 100 + int'(vcount), 1909);

    repeat (4) @(negedge clk);
    sb_on = 1'b0;
    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule